// File: doc/BRIEF.md
# Line-Indexed Branch Target Predictor

This block holds one prediction record per instruction-cache line and is read in step with instruction fetch. The fetch unit presents the index of the line it is fetching; one clock later the block returns whether a taken branch is expected in that line, which line to fetch next if so, and which of the four instruction slots in that line execution resumes at. A small next-fetch selector turns this into the next line index and start slot. When the prediction is not taken, the selector picks the following line at slot zero.

There is no tag, so every fetch index hits its own record. Each record is 15 bits wide: a 10-bit target line index, a 2-bit start slot, a taken flag and two spare bits held at zero. Branch resolution writes a record through a separate update port. If the resolving branch was mispredicted, the block raises a redirect a fixed number of cycles later. The redirect carries the corrected line and slot, and it overrides whatever the table predicts in that cycle.

Top module: `line_branch_predictor`

## Requirements
- R1: A record written through the update port (upd_taken, upd_target, upd_slot at upd_idx) is returned on pred_taken, pred_target and pred_slot when that index is later fetched. Each of the 2^LINE_W records is independent of the others.
- R2: The read is registered. The pred_* outputs and pred_idx reflect the fetch_idx sampled at the previous rising clock edge.
- R3: When the prediction is not taken and no redirect is active, next_idx equals pred_idx plus one (modulo 2^LINE_W) and next_slot is 0.
- R4: When the prediction is taken and no redirect is active, next_idx equals pred_target and next_slot equals pred_slot.
- R5: When an update and a fetch address the same index at the same edge, the fetch returns the newly written record.
- R6: After synchronous reset, every index reads as not taken with target 0 and slot 0, including indices written before the reset.
- R7: An update with upd_mispredict high drives redirect_valid high exactly PENALTY cycles after the cycle in which the update was presented, and low in the cycles before. If the resolved branch was taken, next_idx is upd_target and next_slot is upd_slot during the redirect cycle.
- R8: A mispredicted update that resolves not taken redirects to upd_idx plus one (modulo 2^LINE_W) at slot 0.
- R9: A redirect lasts one cycle per mispredicted update and takes precedence over a taken table prediction in the same cycle. Mispredicts in consecutive cycles give redirects in consecutive cycles, each with its own target.
- R10: While upd_en is low, the values on the update inputs leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_idx | input | LINE_W | Line index being fetched this cycle |
| upd_en | input | 1 | Write a resolved branch record |
| upd_idx | input | LINE_W | Line holding the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | LINE_W | Resolved target line |
| upd_slot | input | SLOT_W | Resolved start slot in the target line |
| upd_mispredict | input | 1 | The resolved branch was mispredicted (qualified by upd_en) |
| pred_idx | output | LINE_W | Fetch index the current prediction belongs to |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | LINE_W | Predicted target line |
| pred_slot | output | SLOT_W | Predicted start slot |
| next_idx | output | LINE_W | Selected next fetch line |
| next_slot | output | SLOT_W | Selected next start slot |
| redirect_valid | output | 1 | Misprediction redirect is active this cycle |

## Verification
The first read sweep covers every index straight after reset and checks that each one yields the sequential successor, including the wrap from the last line to line zero. A second sweep follows a write of an arithmetic pattern to the whole table, mixing taken and not-taken records with scattered targets and all four slots; it tells apart a table that aliases entries or drops fields from one that stores each record independently. Directed patterns then cover a same-index write and read, update inputs that are driven while disabled, taken and not-taken mispredicts, back-to-back mispredicts, and a redirect that collides with a taken prediction. Together these separate correct latency and priority from off-by-one delays and a reversed mux order.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

  // Default geometry of the prediction table.
  localparam int DEF_LINE_W  = 10;
  localparam int DEF_SLOT_W  = 2;
  localparam int SPARE_W     = 2;
  localparam int DEF_PENALTY = 3;

  // Width of one stored record: target, slot, taken flag, spare bits.
  function automatic int rec_width(input int line_w, input int slot_w);
    return line_w + slot_w + 1 + SPARE_W;
  endfunction

  // Source chosen by the next-fetch selector.
  typedef enum logic [1:0] {
    NXT_SEQ   = 2'd0,
    NXT_PRED  = 2'd1,
    NXT_REDIR = 2'd2
  } nxt_src_e;

endpackage

// File: rtl/bpt_table.sv
module bpt_table #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  localparam int DEPTH = 1 << IDX_W;

  // Storage without reset so it can map onto block RAM.
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;

  // One written-since-reset flag per line; clearing these is the reset.
  logic [DEPTH-1:0]  written;
  logic              written_q;

  // Same-index collision bypass, captured at the read edge.
  logic              hit_q;
  logic [DATA_W-1:0] byp_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    mem_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
    end else if (wr_en) begin
      written[wr_addr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      written_q <= written[rd_addr];
      hit_q     <= wr_en && (wr_addr == rd_addr);
    end
  end

  always_ff @(posedge clk) begin
    byp_q <= wr_data;
  end

  always_comb begin
    if (hit_q)          rd_data = byp_q;
    else if (written_q) rd_data = mem_q;
    else                rd_data = '0;
  end

  // R5
  write_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && ($past(wr_addr) == $past(rd_addr)))
      |-> (rd_data == $past(wr_data)));

  // R6
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == '0));

endmodule

// File: rtl/bpt_redirect.sv
module bpt_redirect #(
  parameter int IDX_W   = 10,
  parameter int SLOT_W  = 2,
  parameter int PENALTY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mp_en,
  input  logic [IDX_W-1:0]  mp_idx,
  input  logic              mp_taken,
  input  logic [IDX_W-1:0]  mp_target,
  input  logic [SLOT_W-1:0] mp_slot,
  output logic              redir_valid,
  output logic [IDX_W-1:0]  redir_idx,
  output logic [SLOT_W-1:0] redir_slot
);

  localparam int CNT_W = $clog2(PENALTY + 2);
  localparam logic [CNT_W-1:0] AGE_SAT = CNT_W'(PENALTY + 1);
  localparam logic [CNT_W-1:0] AGE_HIT = CNT_W'(PENALTY);

  // Corrected destination, computed when the branch resolves.
  logic [IDX_W-1:0]  fix_idx;
  logic [SLOT_W-1:0] fix_slot;

  always_comb begin
    if (mp_taken) begin
      fix_idx  = mp_target;
      fix_slot = mp_slot;
    end else begin
      fix_idx  = mp_idx + 1'b1;
      fix_slot = '0;
    end
  end

  // Delay line, one register stage per penalty cycle.
  logic              v_q    [PENALTY];
  logic [IDX_W-1:0]  idx_q  [PENALTY];
  logic [SLOT_W-1:0] slot_q [PENALTY];

  for (genvar g = 0; g < PENALTY; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= mp_en;
        idx_q[g]  <= fix_idx;
        slot_q[g] <= fix_slot;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v_q[g] <= 1'b0;
        else     v_q[g] <= v_q[g-1];
        idx_q[g]  <= idx_q[g-1];
        slot_q[g] <= slot_q[g-1];
      end
    end
  end

  assign redir_valid = v_q[PENALTY-1];
  assign redir_idx   = idx_q[PENALTY-1];
  assign redir_slot  = slot_q[PENALTY-1];

  // Cycles since the most recent mispredict, saturating.
  logic [CNT_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)               age_q <= AGE_SAT;
    else if (mp_en)        age_q <= CNT_W'(1);
    else if (age_q != AGE_SAT) age_q <= age_q + 1'b1;
  end

  // R7
  penalty_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_HIT) |-> redir_valid);

  // R7
  no_stray_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_SAT) |-> !redir_valid);

endmodule

// File: rtl/bpt_next_sel.sv
module bpt_next_sel
  import bpt_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int SLOT_W = 2
) (
  input  logic              redir_valid,
  input  logic [IDX_W-1:0]  redir_idx,
  input  logic [SLOT_W-1:0] redir_slot,
  input  logic              pred_taken,
  input  logic [IDX_W-1:0]  pred_target,
  input  logic [SLOT_W-1:0] pred_slot,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [IDX_W-1:0]  next_idx,
  output logic [SLOT_W-1:0] next_slot
);

  nxt_src_e src;

  always_comb begin
    if (redir_valid)     src = NXT_REDIR;
    else if (pred_taken) src = NXT_PRED;
    else                 src = NXT_SEQ;
  end

  always_comb begin
    unique case (src)
      NXT_REDIR: begin
        next_idx  = redir_idx;
        next_slot = redir_slot;
      end
      NXT_PRED: begin
        next_idx  = pred_target;
        next_slot = pred_slot;
      end
      default: begin
        next_idx  = cur_idx + 1'b1;
        next_slot = '0;
      end
    endcase
  end

endmodule

// File: rtl/line_branch_predictor.sv
module line_branch_predictor
  import bpt_pkg::*;
#(
  parameter int LINE_W  = DEF_LINE_W,
  parameter int SLOT_W  = DEF_SLOT_W,
  parameter int PENALTY = DEF_PENALTY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] fetch_idx,
  input  logic              upd_en,
  input  logic [LINE_W-1:0] upd_idx,
  input  logic              upd_taken,
  input  logic [LINE_W-1:0] upd_target,
  input  logic [SLOT_W-1:0] upd_slot,
  input  logic              upd_mispredict,
  output logic [LINE_W-1:0] pred_idx,
  output logic              pred_taken,
  output logic [LINE_W-1:0] pred_target,
  output logic [SLOT_W-1:0] pred_slot,
  output logic [LINE_W-1:0] next_idx,
  output logic [SLOT_W-1:0] next_slot,
  output logic              redirect_valid
);

  localparam int REC_W   = rec_width(LINE_W, SLOT_W);
  localparam int TGT_LO  = 0;
  localparam int SLOT_LO = TGT_LO + LINE_W;
  localparam int TKN_BIT = SLOT_LO + SLOT_W;
  localparam int SPR_LO  = TKN_BIT + 1;

  logic [REC_W-1:0] wr_rec;
  logic [REC_W-1:0] rd_rec;

  assign wr_rec = {{SPARE_W{1'b0}}, upd_taken, upd_slot, upd_target};

  bpt_table #(
    .IDX_W  (LINE_W),
    .DATA_W (REC_W)
  ) u_table (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (fetch_idx),
    .rd_data (rd_rec),
    .wr_en   (upd_en),
    .wr_addr (upd_idx),
    .wr_data (wr_rec)
  );

  // Fetch index registered alongside the table read.
  always_ff @(posedge clk) begin
    if (rst) pred_idx <= '0;
    else     pred_idx <= fetch_idx;
  end

  assign pred_target = rd_rec[TGT_LO +: LINE_W];
  assign pred_slot   = rd_rec[SLOT_LO +: SLOT_W];
  assign pred_taken  = rd_rec[TKN_BIT];

  logic [SPARE_W-1:0] unused_spare;
  assign unused_spare = rd_rec[SPR_LO +: SPARE_W];

  logic [LINE_W-1:0] redir_idx;
  logic [SLOT_W-1:0] redir_slot;

  bpt_redirect #(
    .IDX_W   (LINE_W),
    .SLOT_W  (SLOT_W),
    .PENALTY (PENALTY)
  ) u_redirect (
    .clk         (clk),
    .rst         (rst),
    .mp_en       (upd_en && upd_mispredict),
    .mp_idx      (upd_idx),
    .mp_taken    (upd_taken),
    .mp_target   (upd_target),
    .mp_slot     (upd_slot),
    .redir_valid (redirect_valid),
    .redir_idx   (redir_idx),
    .redir_slot  (redir_slot)
  );

  bpt_next_sel #(
    .IDX_W  (LINE_W),
    .SLOT_W (SLOT_W)
  ) u_next (
    .redir_valid (redirect_valid),
    .redir_idx   (redir_idx),
    .redir_slot  (redir_slot),
    .pred_taken  (pred_taken),
    .pred_target (pred_target),
    .pred_slot   (pred_slot),
    .cur_idx     (pred_idx),
    .next_idx    (next_idx),
    .next_slot   (next_slot)
  );

  // R3
  seq_successor_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !redirect_valid && !pred_taken)
      |-> ((next_idx == LINE_W'($past(fetch_idx) + 1'b1)) && (next_slot == '0)));

  // R2
  idx_echo_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pred_idx == $past(fetch_idx)));

endmodule

// File: tb/line_branch_predictor_test.sv
`timescale 1ns/1ps
module line_branch_predictor_test;

  localparam int LW    = 10;
  localparam int SW    = 2;
  localparam int PEN   = 3;
  localparam int DEPTH = 1 << LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] fetch_idx = '0;
  logic          upd_en = 1'b0;
  logic [LW-1:0] upd_idx = '0;
  logic          upd_taken = 1'b0;
  logic [LW-1:0] upd_target = '0;
  logic [SW-1:0] upd_slot = '0;
  logic          upd_mispredict = 1'b0;
  logic [LW-1:0] pred_idx;
  logic          pred_taken;
  logic [LW-1:0] pred_target;
  logic [SW-1:0] pred_slot;
  logic [LW-1:0] next_idx;
  logic [SW-1:0] next_slot;
  logic          redirect_valid;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  line_branch_predictor #(.LINE_W(LW), .SLOT_W(SW), .PENALTY(PEN)) uut (
    .clk(clk), .rst(rst), .fetch_idx(fetch_idx),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_slot(upd_slot), .upd_mispredict(upd_mispredict),
    .pred_idx(pred_idx), .pred_taken(pred_taken), .pred_target(pred_target),
    .pred_slot(pred_slot), .next_idx(next_idx), .next_slot(next_slot),
    .redirect_valid(redirect_valid)
  );

  function automatic bit pat_taken(int i);  return (i % 3) != 0; endfunction
  function automatic int pat_tgt(int i);    return (i * 37 + 5) % DEPTH; endfunction
  function automatic int pat_slot(int i);   return i % 4; endfunction

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Compare all prediction outputs against one expected record.
  task automatic chk_read(input string req, input int idx, input bit tk,
                          input int tgt, input int sl);
    int en, es;
    en = tk ? tgt : (idx + 1) % DEPTH;
    es = tk ? sl : 0;
    chk(req, "pred_idx",    pred_idx, idx);
    chk(req, "pred_taken",  pred_taken, tk);
    chk(req, "pred_target", pred_target, tk ? tgt : pred_target);
    chk(req, "pred_slot",   pred_slot, tk ? sl : pred_slot);
    chk(req, "next_idx",    next_idx, en);
    chk(req, "next_slot",   next_slot, es);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R6: reset state
    repeat (3) step();
    chk("R6", "pred_taken in reset", pred_taken, 0);
    chk("R6", "redirect in reset", redirect_valid, 0);
    rst = 1'b0;

    // R6 R3 R2: every line reads not taken and steps to its successor
    for (int i = 0; i < DEPTH; i++) begin
      fetch_idx = LW'(i);
      step();
      chk_read("R6", i, 1'b0, 0, 0);
      chk("R6", "target after reset", pred_target, 0);
      chk("R6", "slot after reset", pred_slot, 0);
    end

    // R1: fill the table with an arithmetic pattern
    for (int i = 0; i < DEPTH; i++) begin
      upd_en = 1'b1;
      upd_idx = LW'(i);
      upd_taken = pat_taken(i);
      upd_target = LW'(pat_tgt(i));
      upd_slot = SW'(pat_slot(i));
      fetch_idx = LW'((i + DEPTH / 2) % DEPTH);
      step();
    end
    upd_en = 1'b0;

    // R1 R4 R3: read back every line
    for (int i = 0; i < DEPTH; i++) begin
      fetch_idx = LW'(i);
      step();
      chk_read(pat_taken(i) ? "R4" : "R3", i, pat_taken(i), pat_tgt(i), pat_slot(i));
      chk("R1", "stored target", pred_target, pat_tgt(i));
      chk("R1", "stored slot", pred_slot, pat_slot(i));
    end

    // R10: update inputs driven while disabled
    upd_en = 1'b0; upd_idx = 5; upd_taken = 1'b0; upd_target = 77; upd_slot = 2;
    upd_mispredict = 1'b1;
    fetch_idx = 5;
    step(); step();
    chk_read("R10", 5, pat_taken(5), pat_tgt(5), pat_slot(5));
    chk("R10", "no redirect while disabled", redirect_valid, 0);
    step(); step();
    chk("R10", "no late redirect while disabled", redirect_valid, 0);
    upd_mispredict = 1'b0;

    // R5: write and read of the same line at the same edge
    upd_en = 1'b1; upd_idx = 7; upd_taken = 1'b1; upd_target = 999; upd_slot = 3;
    fetch_idx = 7;
    step();
    upd_en = 1'b0;
    chk_read("R5", 7, 1'b1, 999, 3);
    step();
    chk_read("R5", 7, 1'b1, 999, 3);

    // R7 R9: taken mispredict colliding with a taken table prediction
    upd_en = 1'b1; upd_mispredict = 1'b1; upd_idx = 100; upd_taken = 1'b1;
    upd_target = 300; upd_slot = 2; fetch_idx = 0;
    for (int j = 1; j <= PEN; j++) begin
      if (j == PEN) fetch_idx = 4;
      step();
      upd_en = 1'b0; upd_mispredict = 1'b0;
      chk("R7", "redirect timing", redirect_valid, (j == PEN) ? 1 : 0);
    end
    chk("R9", "table still predicts taken", pred_taken, 1);
    chk("R7", "redirect next_idx", next_idx, 300);
    chk("R7", "redirect next_slot", next_slot, 2);
    step();
    chk("R9", "redirect lasts one cycle", redirect_valid, 0);
    chk_read("R9", 4, 1'b1, pat_tgt(4), pat_slot(4));

    // R8: not-taken mispredict at the last line wraps to line zero
    upd_en = 1'b1; upd_mispredict = 1'b1; upd_idx = LW'(DEPTH - 1); upd_taken = 1'b0;
    upd_target = 55; upd_slot = 3;
    for (int j = 1; j <= PEN; j++) begin
      step();
      upd_en = 1'b0; upd_mispredict = 1'b0;
    end
    chk("R8", "redirect valid", redirect_valid, 1);
    chk("R8", "redirect next_idx", next_idx, 0);
    chk("R8", "redirect next_slot", next_slot, 0);

    // R9: back-to-back mispredicts
    step();
    upd_en = 1'b1; upd_mispredict = 1'b1; upd_idx = 10; upd_taken = 1'b1;
    upd_target = 20; upd_slot = 1;
    step();
    upd_idx = 11; upd_taken = 1'b0; upd_target = 40; upd_slot = 3;
    step();
    upd_en = 1'b0; upd_mispredict = 1'b0;
    for (int j = 3; j <= PEN; j++) step();
    chk("R9", "first redirect valid", redirect_valid, 1);
    chk("R9", "first redirect idx", next_idx, 20);
    chk("R9", "first redirect slot", next_slot, 1);
    step();
    chk("R9", "second redirect valid", redirect_valid, 1);
    chk("R8", "second redirect idx", next_idx, 12);
    chk("R8", "second redirect slot", next_slot, 0);
    step();
    chk("R9", "redirects end", redirect_valid, 0);

    // R6: reset clears previously written lines
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
    fetch_idx = 4;
    step();
    chk_read("R6", 4, 1'b0, 0, 0);
    fetch_idx = 7;
    step();
    chk_read("R6", 7, 1'b0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule